// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

This block sits behind the instruction decoder and turns memory-ordering and cache-management instructions into request sequences aimed at three responders: the L1 data cache, the instruction cache and the TLB. An instruction word and the value of its first source register arrive through a valid/ready handshake. The block classifies the word, latches any line address and issues one or two requests. Each request is either whole-structure or single-line, and it stays asserted until the target acknowledges it. When the final acknowledge of a sequence arrives, the block pulses a completion flag. A word it does not recognise produces a one-cycle illegal flag and no requests.

The three cache-block operations (invalidate, clean, flush) all perform a single data-cache line flush. The block has no discard-without-writeback path. An instruction-fence form whose source register field is non-zero flushes a single instruction-cache line instead of the whole instruction cache. A custom system-space encoding invalidates the entire TLB.

Top module: `cmo_sequencer`

## Requirements
- R1: A data-ordering fence (opcode 0001111, funct3 000, with rd, rs1 field and imm12 all zero) issues exactly one whole-cache request to the data cache and no other request.
- R2: A whole instruction fence (opcode 0001111, funct3 001, with rd, rs1 field and imm12 all zero) issues a whole data-cache request first. The whole instruction-cache request becomes valid only in the cycle after the data-cache acknowledge.
- R3: An instruction fence with rd zero, a non-zero rs1 field and imm12 zero issues exactly one instruction-cache line request, carrying the aligned rs1 value.
- R4: A cache-block operation (opcode 0001111, funct3 010, rd zero, imm12 equal to 0, 1 or 2) issues exactly one data-cache line request. The request is the same for all three immediate values.
- R5: A line request carries the rs1 value rounded down to a multiple of 64 bytes and has its line flag set to 1. A whole request has its line flag at 0 and its address at 0.
- R6: The TLB-invalidate word (opcode 1110011, funct3 000, rd zero, rs1 field zero, imm12 0x7C0) issues exactly one TLB request.
- R7: Any other accepted word raises illegalP for exactly the cycle after acceptance and issues no request.
- R8: A request valid stays high with a stable address until its acknowledge is sampled. instReady is low from the cycle after acceptance of a valid operation until its sequence ends, so words offered in that time are not taken.
- R9: doneP is high for exactly the cycle after the final acknowledge of a sequence. instReady is high again in that same cycle.
- R10: At most one of the three request valids is high in any cycle.
- R11: After reset, instReady is high and every request valid, doneP and illegalP are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Sequencer idle and able to accept |
| instWord | input | 32 | Instruction word |
| rs1Val | input | ADDR_W | Value of the first source register |
| dcReqValid | output | 1 | Data-cache request |
| dcReqLine | output | 1 | 1 = single line, 0 = whole cache |
| dcReqAddr | output | ADDR_W | Data-cache line address |
| dcAck | input | 1 | Data-cache acknowledge |
| icReqValid | output | 1 | Instruction-cache request |
| icReqLine | output | 1 | 1 = single line, 0 = whole cache |
| icReqAddr | output | ADDR_W | Instruction-cache line address |
| icAck | input | 1 | Instruction-cache acknowledge |
| tlbReqValid | output | 1 | Whole-TLB invalidate request |
| tlbAck | input | 1 | TLB acknowledge |
| doneP | output | 1 | Sequence-complete pulse |
| illegalP | output | 1 | Unrecognised-word pulse |

## Verification
A wrong sequencer state becomes visible at the ports within one cycle. The symptoms are a request valid on the wrong target, a missing or early instruction-cache request after the data-cache acknowledge, instReady high while a request is pending, or a completion pulse in the wrong cycle. A wrong latched address or line flag shows on the first cycle the request is valid. The bench compares every output against a queue-based reference on every clock, so a fault is reported in the cycle where it first appears.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  localparam logic [6:0]  OPC_MISC_MEM = 7'b0001111;
  localparam logic [6:0]  OPC_SYSTEM   = 7'b1110011;
  localparam logic [2:0]  F3_FENCE     = 3'b000;
  localparam logic [2:0]  F3_FENCE_I   = 3'b001;
  localparam logic [2:0]  F3_CBO       = 3'b010;
  localparam logic [2:0]  F3_PRIV      = 3'b000;
  localparam logic [11:0] IMM_TLB_ALL  = 12'h7C0;
  localparam logic [11:0] IMM_CBO_MAX  = 12'd2;

  typedef enum logic [2:0] {
    OP_DATA_FENCE,
    OP_IFENCE_ALL,
    OP_IFENCE_LINE,
    OP_DC_LINE,
    OP_TLB_ALL,
    OP_BAD
  } cmoOpE;

  typedef struct packed {
    logic loadAddr;
    logic dcLine;
    logic icLine;
  } dpStrobeS;
endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
  import cmo_pkg::*;
(
  input  logic [31:0] instWord,
  output cmoOpE       op
);
  logic [6:0]  opcode;
  logic [4:0]  rdF;
  logic [2:0]  funct3;
  logic [4:0]  rs1F;
  logic [11:0] imm;
  logic        rdZero;
  logic        rs1Zero;
  logic        immZero;

  assign opcode  = instWord[6:0];
  assign rdF     = instWord[11:7];
  assign funct3  = instWord[14:12];
  assign rs1F    = instWord[19:15];
  assign imm     = instWord[31:20];
  assign rdZero  = (rdF == 5'd0);
  assign rs1Zero = (rs1F == 5'd0);
  assign immZero = (imm == 12'd0);

  always_comb begin
    op = OP_BAD;
    if (opcode == OPC_MISC_MEM) begin
      unique case (funct3)
        F3_FENCE: begin
          if (rdZero && rs1Zero && immZero) op = OP_DATA_FENCE;
        end
        F3_FENCE_I: begin
          if (rdZero && immZero) op = rs1Zero ? OP_IFENCE_ALL : OP_IFENCE_LINE;
        end
        F3_CBO: begin
          if (rdZero && (imm <= IMM_CBO_MAX)) op = OP_DC_LINE;
        end
        default: op = OP_BAD;
      endcase
    end else if (opcode == OPC_SYSTEM) begin
      if (funct3 == F3_PRIV && rdZero && rs1Zero && imm == IMM_TLB_ALL)
        op = OP_TLB_ALL;
    end
  end
endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
  import cmo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     instValid,
  input  cmoOpE    op,
  input  logic     dcAck,
  input  logic     icAck,
  input  logic     tlbAck,
  output logic     instReady,
  output logic     dcReqValid,
  output logic     icReqValid,
  output logic     tlbReqValid,
  output logic     doneP,
  output logic     illegalP,
  output dpStrobeS strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_DC, ST_IC, ST_TLB} stateE;

  stateE stQ;
  logic  icAfterDcQ;
  logic  accept;

  assign instReady   = (stQ == ST_IDLE);
  assign accept      = instReady && instValid;
  assign dcReqValid  = (stQ == ST_DC);
  assign icReqValid  = (stQ == ST_IC);
  assign tlbReqValid = (stQ == ST_TLB);

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = accept;
    strobe.dcLine   = (op == OP_DC_LINE);
    strobe.icLine   = (op == OP_IFENCE_LINE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ        <= ST_IDLE;
      icAfterDcQ <= 1'b0;
      doneP      <= 1'b0;
      illegalP   <= 1'b0;
    end else begin
      doneP    <= 1'b0;
      illegalP <= 1'b0;
      unique case (stQ)
        ST_IDLE: begin
          if (accept) begin
            unique case (op)
              OP_DATA_FENCE: begin stQ <= ST_DC; icAfterDcQ <= 1'b0; end
              OP_IFENCE_ALL: begin stQ <= ST_DC; icAfterDcQ <= 1'b1; end
              OP_IFENCE_LINE: stQ <= ST_IC;
              OP_DC_LINE:    begin stQ <= ST_DC; icAfterDcQ <= 1'b0; end
              OP_TLB_ALL:    stQ <= ST_TLB;
              default:       illegalP <= 1'b1;
            endcase
          end
        end
        ST_DC: begin
          if (dcAck) begin
            if (icAfterDcQ) begin
              stQ        <= ST_IC;
              icAfterDcQ <= 1'b0;
            end else begin
              stQ   <= ST_IDLE;
              doneP <= 1'b1;
            end
          end
        end
        ST_IC: begin
          if (icAck) begin
            stQ   <= ST_IDLE;
            doneP <= 1'b1;
          end
        end
        ST_TLB: begin
          if (tlbAck) begin
            stQ   <= ST_IDLE;
            doneP <= 1'b1;
          end
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dcReqValid, icReqValid, tlbReqValid}))
    else $error("R10 more than one request valid");

  assert_dc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    dcReqValid && !dcAck |=> dcReqValid)
    else $error("R8 data request dropped before ack");

  assert_ic_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    icReqValid && !icAck |=> icReqValid)
    else $error("R8 instruction request dropped before ack");

  assert_tlb_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    tlbReqValid && !tlbAck |=> tlbReqValid)
    else $error("R8 TLB request dropped before ack");

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    instReady |-> !(dcReqValid || icReqValid || tlbReqValid))
    else $error("R8 ready while a request is pending");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP)
    else $error("R9 completion pulse longer than one cycle");

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> $past((dcReqValid && dcAck) || (icReqValid && icAck) || (tlbReqValid && tlbAck)))
    else $error("R9 completion without a final acknowledge");

  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalP |-> instReady && !doneP)
    else $error("R7 illegal flag alongside a sequence");
endmodule

// File: rtl/cmo_datapath.sv
module cmo_datapath
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeS          strobe,
  input  logic [ADDR_W-1:0] rs1Val,
  output logic              dcReqLine,
  output logic [ADDR_W-1:0] dcReqAddr,
  output logic              icReqLine,
  output logic [ADDR_W-1:0] icReqAddr
);
  localparam int OFFSET_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((64'd1 << OFFSET_W) - 64'd1);

  logic [ADDR_W-1:0] lineAddrQ;
  logic              dcLineQ;
  logic              icLineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAddrQ <= '0;
      dcLineQ   <= 1'b0;
      icLineQ   <= 1'b0;
    end else if (strobe.loadAddr) begin
      lineAddrQ <= rs1Val & ~LINE_MASK;
      dcLineQ   <= strobe.dcLine;
      icLineQ   <= strobe.icLine;
    end
  end

  assign dcReqLine = dcLineQ;
  assign icReqLine = icLineQ;
  assign dcReqAddr = dcLineQ ? lineAddrQ : '0;
  assign icReqAddr = icLineQ ? lineAddrQ : '0;

  assert_dc_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dcReqAddr & LINE_MASK) == '0)
    else $error("R5 data line address not aligned");

  assert_ic_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (icReqAddr & LINE_MASK) == '0)
    else $error("R5 instruction line address not aligned");
endmodule

// File: rtl/cmo_sequencer.sv
module cmo_sequencer
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  output logic              instReady,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] rs1Val,
  output logic              dcReqValid,
  output logic              dcReqLine,
  output logic [ADDR_W-1:0] dcReqAddr,
  input  logic              dcAck,
  output logic              icReqValid,
  output logic              icReqLine,
  output logic [ADDR_W-1:0] icReqAddr,
  input  logic              icAck,
  output logic              tlbReqValid,
  input  logic              tlbAck,
  output logic              doneP,
  output logic              illegalP
);
  cmoOpE    op;
  dpStrobeS strobe;

  cmo_decode uDecode (
    .instWord (instWord),
    .op       (op)
  );

  cmo_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .instValid   (instValid),
    .op          (op),
    .dcAck       (dcAck),
    .icAck       (icAck),
    .tlbAck      (tlbAck),
    .instReady   (instReady),
    .dcReqValid  (dcReqValid),
    .icReqValid  (icReqValid),
    .tlbReqValid (tlbReqValid),
    .doneP       (doneP),
    .illegalP    (illegalP),
    .strobe      (strobe)
  );

  cmo_datapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rs1Val    (rs1Val),
    .dcReqLine (dcReqLine),
    .dcReqAddr (dcReqAddr),
    .icReqLine (icReqLine),
    .icReqAddr (icReqAddr)
  );

  assert_ifence_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(icReqValid) && !icReqLine |-> $past(dcReqValid && dcAck))
    else $error("R2 whole instruction flush before data flush finished");

  assert_dc_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    dcReqValid && !dcAck |=> $stable(dcReqAddr) && $stable(dcReqLine))
    else $error("R8 data request address moved while pending");

  assert_ic_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    icReqValid && !icAck |=> $stable(icReqAddr) && $stable(icReqLine))
    else $error("R8 instruction request address moved while pending");
endmodule

// File: tb/tb_cmo_sequencer.sv
`timescale 1ns/1ps
module tb_cmo_sequencer;
  localparam int AW = 64;

  typedef struct {
    int          tgt;
    bit          line;
    logic [63:0] addr;
  } reqT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic          instReady;
  logic [31:0]   instWord = '0;
  logic [AW-1:0] rs1Val = '0;
  logic          dcReqValid, dcReqLine, icReqValid, icReqLine, tlbReqValid;
  logic [AW-1:0] dcReqAddr, icReqAddr;
  logic          dcAck = 1'b0, icAck = 1'b0, tlbAck = 1'b0;
  logic          doneP, illegalP;

  int checks = 0;
  int fails = 0;
  string curTag = "R11";

  reqT q[$];
  bit  mDone = 0;
  bit  mIll = 0;
  bit  compareOn = 0;

  always #2.5 clk = ~clk;

  cmo_sequencer dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instWord(instWord), .rs1Val(rs1Val),
    .dcReqValid(dcReqValid), .dcReqLine(dcReqLine), .dcReqAddr(dcReqAddr), .dcAck(dcAck),
    .icReqValid(icReqValid), .icReqLine(icReqLine), .icReqAddr(icReqAddr), .icAck(icAck),
    .tlbReqValid(tlbReqValid), .tlbAck(tlbAck), .doneP(doneP), .illegalP(illegalP)
  );

  function automatic logic [31:0] enc(input logic [11:0] imm, input logic [4:0] rs1f,
                                      input logic [2:0] f3, input logic [4:0] rd,
                                      input logic [6:0] opc);
    return {imm, rs1f, f3, rd, opc};
  endfunction

  // Reference classification, written from the requirement text
  function automatic void refPush(input logic [31:0] w, input logic [63:0] r, output bit bad);
    reqT e;
    logic [63:0] al;
    al = {r[63:6], 6'b0};
    bad = 0;
    if (w == enc(12'h000, 5'd0, 3'd0, 5'd0, 7'h0F)) begin              // R1
      e.tgt = 0; e.line = 0; e.addr = 0; q.push_back(e);
    end else if (w == enc(12'h000, 5'd0, 3'd1, 5'd0, 7'h0F)) begin     // R2
      e.tgt = 0; e.line = 0; e.addr = 0; q.push_back(e);
      e.tgt = 1; q.push_back(e);
    end else if (w[6:0] == 7'h0F && w[14:12] == 3'd1 && w[11:7] == 0 &&
                 w[31:20] == 0 && w[19:15] != 0) begin                  // R3
      e.tgt = 1; e.line = 1; e.addr = al; q.push_back(e);
    end else if (w[6:0] == 7'h0F && w[14:12] == 3'd2 && w[11:7] == 0 &&
                 (w[31:20] == 0 || w[31:20] == 1 || w[31:20] == 2)) begin // R4
      e.tgt = 0; e.line = 1; e.addr = al; q.push_back(e);
    end else if (w == enc(12'h7C0, 5'd0, 3'd0, 5'd0, 7'h73)) begin     // R6
      e.tgt = 2; e.line = 0; e.addr = 0; q.push_back(e);
    end else begin
      bad = 1;                                                          // R7
    end
  endfunction

  // Behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mDone = 0; mIll = 0;
    end else begin
      bit ackHead;
      bit bad;
      mDone = 0; mIll = 0;
      if (q.size() > 0) begin
        ackHead = (q[0].tgt == 0) ? dcAck : (q[0].tgt == 1) ? icAck : tlbAck;
        if (ackHead) begin
          void'(q.pop_front());
          if (q.size() == 0) mDone = 1;
        end
      end else if (instValid) begin
        refPush(instWord, rs1Val, bad);
        mIll = bad;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (compareOn) begin
      bit eDc, eIc, eTlb, eLine;
      logic [63:0] eAddr;
      eDc = 0; eIc = 0; eTlb = 0; eLine = 0; eAddr = 0;
      if (q.size() > 0) begin
        eDc = (q[0].tgt == 0); eIc = (q[0].tgt == 1); eTlb = (q[0].tgt == 2);
        eLine = q[0].line; eAddr = q[0].addr;
      end
      chk(instReady == (q.size() == 0), "R8", "instReady", 64'(instReady), 64'(q.size() == 0));
      chk(dcReqValid == eDc, curTag, "dcReqValid", 64'(dcReqValid), 64'(eDc));
      chk(icReqValid == eIc, curTag, "icReqValid", 64'(icReqValid), 64'(eIc));
      chk(tlbReqValid == eTlb, curTag, "tlbReqValid", 64'(tlbReqValid), 64'(eTlb));
      chk($countones({dcReqValid, icReqValid, tlbReqValid}) <= 1, "R10", "valid count",
          64'($countones({dcReqValid, icReqValid, tlbReqValid})), 64'd1);
      if (eDc) begin
        chk(dcReqLine == eLine, "R5", "dcReqLine", 64'(dcReqLine), 64'(eLine));
        chk(dcReqAddr == eAddr, "R5", "dcReqAddr", dcReqAddr, eAddr);
      end
      if (eIc) begin
        chk(icReqLine == eLine, "R5", "icReqLine", 64'(icReqLine), 64'(eLine));
        chk(icReqAddr == eAddr, "R5", "icReqAddr", icReqAddr, eAddr);
      end
      chk(doneP == mDone, "R9", "doneP", 64'(doneP), 64'(mDone));
      chk(illegalP == mIll, "R7", "illegalP", 64'(illegalP), 64'(mIll));
    end
  end

  // Responders with a varying acknowledge delay
  int dly [3] = '{0, 0, 0};
  int seed = 1;
  always @(negedge clk) begin
    if (!rstN) begin
      dcAck <= 0; icAck <= 0; tlbAck <= 0;
    end else begin
      if (dcAck) begin dcAck <= 0; seed = (seed * 5 + 3) % 11; dly[0] = seed % 4; end
      else if (dcReqValid) begin if (dly[0] == 0) dcAck <= 1; else dly[0]--; end
      if (icAck) begin icAck <= 0; seed = (seed * 5 + 3) % 11; dly[1] = seed % 4; end
      else if (icReqValid) begin if (dly[1] == 0) icAck <= 1; else dly[1]--; end
      if (tlbAck) begin tlbAck <= 0; seed = (seed * 5 + 3) % 11; dly[2] = seed % 3; end
      else if (tlbReqValid) begin if (dly[2] == 0) tlbAck <= 1; else dly[2]--; end
    end
  end

  task automatic issue(input logic [31:0] w, input logic [63:0] r, input string tag);
    bit wasReady;
    @(negedge clk);
    curTag = tag;
    instWord = w; rs1Val = r; instValid = 1;
    forever begin
      wasReady = instReady;
      @(negedge clk);
      if (wasReady) break;
    end
    instValid = 0;
    instWord = 32'h0000_0013;
  endtask

  task automatic drain();
    while (q.size() > 0 || !instReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11: idle outputs after reset
    chk(instReady && !dcReqValid && !icReqValid && !tlbReqValid && !doneP && !illegalP,
        "R11", "reset outputs",
        64'({instReady, dcReqValid, icReqValid, tlbReqValid, doneP, illegalP}), 64'b100000);
    compareOn = 1;

    issue(enc(12'h000, 5'd0, 3'd0, 5'd0, 7'h0F), 64'hDEAD_BEEF, "R1"); drain();
    issue(enc(12'h000, 5'd0, 3'd1, 5'd0, 7'h0F), 64'h55, "R2"); drain();
    issue(enc(12'h000, 5'd7, 3'd1, 5'd0, 7'h0F), 64'h1234_567F, "R3"); drain();
    issue(enc(12'h000, 5'd3, 3'd2, 5'd0, 7'h0F), 64'h8000_0000_0000_00C1, "R4"); drain();
    issue(enc(12'h001, 5'd3, 3'd2, 5'd0, 7'h0F), 64'h8000_0000_0000_00C1, "R4"); drain();
    issue(enc(12'h002, 5'd3, 3'd2, 5'd0, 7'h0F), 64'h8000_0000_0000_00C1, "R4"); drain();
    issue(enc(12'h002, 5'd9, 3'd2, 5'd0, 7'h0F), 64'h40, "R5"); drain();
    issue(enc(12'h7C0, 5'd0, 3'd0, 5'd0, 7'h73), 64'h0, "R6"); drain();

    // R7: near-miss and foreign encodings
    issue(enc(12'h000, 5'd0, 3'd0, 5'd1, 7'h0F), 64'h0, "R7"); drain();
    issue(enc(12'h0FF, 5'd0, 3'd0, 5'd0, 7'h0F), 64'h0, "R7"); drain();
    issue(enc(12'h000, 5'd0, 3'd1, 5'd2, 7'h0F), 64'h0, "R7"); drain();
    issue(enc(12'h004, 5'd1, 3'd1, 5'd0, 7'h0F), 64'h0, "R7"); drain();
    issue(enc(12'h003, 5'd1, 3'd2, 5'd0, 7'h0F), 64'h80, "R7"); drain();
    issue(enc(12'h001, 5'd1, 3'd2, 5'd4, 7'h0F), 64'h80, "R7"); drain();
    issue(enc(12'h000, 5'd0, 3'd3, 5'd0, 7'h0F), 64'h0, "R7"); drain();
    issue(enc(12'h000, 5'd0, 3'd0, 5'd0, 7'h73), 64'h0, "R7"); drain();
    issue(enc(12'h7C0, 5'd1, 3'd0, 5'd0, 7'h73), 64'h0, "R7"); drain();
    issue(32'h0020_81B3, 64'h0, "R7"); drain();
    issue(enc(12'h000, 5'd0, 3'd0, 5'd1, 7'h0F), 64'h0, "R7");
    issue(enc(12'h003, 5'd0, 3'd2, 5'd0, 7'h0F), 64'h0, "R7"); drain();

    // R8: a word held while the sequencer is busy is taken only when it returns idle
    issue(enc(12'h000, 5'd0, 3'd1, 5'd0, 7'h0F), 64'h0, "R8");
    issue(enc(12'h7C0, 5'd0, 3'd0, 5'd0, 7'h73), 64'h0, "R8");
    issue(enc(12'h000, 5'd5, 3'd1, 5'd0, 7'h0F), 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    drain();

    // Mixed back-to-back stream
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      logic [63:0] r;
      r = 64'h1000 * i + 64'(i * 37);
      case (i % 7)
        0: w = enc(12'h000, 5'd0, 3'd0, 5'd0, 7'h0F);
        1: w = enc(12'h000, 5'd0, 3'd1, 5'd0, 7'h0F);
        2: w = enc(12'h000, 5'(i), 3'd1, 5'd0, 7'h0F);
        3: w = enc(12'(i % 3), 5'd6, 3'd2, 5'd0, 7'h0F);
        4: w = enc(12'h7C0, 5'd0, 3'd0, 5'd0, 7'h73);
        5: w = enc(12'(i % 5), 5'd6, 3'd2, 5'(i % 2), 7'h0F);
        default: w = enc(12'h000, 5'd0, 3'(i % 8), 5'd0, 7'h0F);
      endcase
      issue(w, r, "R9");
    end
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule